// File: doc/BRIEF.md
# Packed Halving Add/Subtract Unit

This execution unit sits beside the integer ALU of a RISC-V style core. It takes two source registers of XLEN bits (32 or 64) and the 32-bit instruction word. It splits both sources into byte, halfword or word lanes and adds or subtracts matching lanes. Each lane result is halved. The sum or difference is formed one bit wider than the lane, and the low bit is then dropped, so a lane can neither overflow nor saturate. Signed lanes round toward negative infinity. For unsigned lanes, the carry or borrow becomes the top bit of the lane result.

The unit decodes the opcode, funct3 and funct7 fields and raises a legal flag for the twelve halving forms. For any other encoding the flag is low and the result is zero. The source and destination register indices are passed out for the core's register file logic. When XLEN is 32, the word form works on the whole register as one scalar 32-bit lane. A parameter adds a registered output stage, and the valid flag follows the data through that stage.

Top module: `halving_simd_alu`

## Requirements
- R1: An instruction is legal when opcode (bits [6:0]) is 0111011, funct3 (bits [14:12]) is 000, funct7 bit 6 is 1, funct7 bits [3:2] are 11 and funct7 bits [1:0] are 10 (byte lanes), 00 (halfword lanes) or 01 (word lanes). funct7 bit 5 selects subtract and funct7 bit 4 selects unsigned.
- R2: Every other encoding, including funct7 bits [1:0] = 11, drives the legal flag low and the result to zero.
- R3: A signed add lane returns floor((a+b)/2) of the two sign-extended elements, with no overflow at the most-positive or most-negative values.
- R4: An unsigned add lane returns (a+b)>>1 over N+1 bits, so the carry becomes the top result bit.
- R5: A signed subtract lane returns floor((a-b)/2) of the sign-extended elements.
- R6: An unsigned subtract lane returns bits [N:1] of the (N+1)-bit wrapped difference, so a borrow shows as the lane's top bit.
- R7: There are XLEN/N lanes. Lane i occupies bits [i*N +: N] of each source and of the result, and no lane affects another.
- R8: With XLEN 32, the word form is one scalar 32-bit halving operation on the full register. With XLEN 64, it acts on two 32-bit lanes.
- R9: The rd, rs1 and rs2 index fields (bits [11:7], [19:15], [24:20]) appear unchanged on their outputs.
- R10: With REG_OUT=1, all outputs appear one clock after the inputs, out_valid follows in_valid by one clock, and reset clears out_valid, legal and the result. With REG_OUT=0, the outputs are combinational and out_valid equals in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands and instruction are valid |
| insn | input | 32 | Instruction word |
| src_a | input | XLEN | First source register value |
| src_b | input | XLEN | Second source register value |
| out_valid | output | 1 | Result is valid |
| legal | output | 1 | Instruction is a recognised halving form |
| result | output | XLEN | Lane-wise halved sum or difference |
| rd_idx | output | 5 | Destination register index |
| rs1_idx | output | 5 | First source register index |
| rs2_idx | output | 5 | Second source register index |

## Verification
The bench builds two copies that share one stimulus stream. The first uses XLEN=64 with REG_OUT=1. It exposes eight byte lanes, four halfword lanes, the packed two-word form and the one-cycle register stage. The second uses XLEN=32 with REG_OUT=0. It exposes the scalar 32-bit meaning of the word encoding and the combinational path. Each result is compared with a wide-integer reference at lane extremes, with equal operands, with borrowing unsigned differences and with illegal encodings.

// File: rtl/halving_simd_alu.sv
module halving_simd_alu #(
  parameter int XLEN    = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic            out_valid,
  output logic            legal,
  output logic [XLEN-1:0] result,
  output logic [4:0]      rd_idx,
  output logic [4:0]      rs1_idx,
  output logic [4:0]      rs2_idx
);

  localparam logic [6:0] OPC = 7'b0111011;
  localparam int NW = 3;

  logic [6:0] f7;
  logic       is_sub, is_uns, c_legal;
  logic [NW-1:0][XLEN-1:0] lane_res;
  logic [XLEN-1:0] c_res;

  assign f7     = insn[31:25];
  assign is_sub = f7[5];
  assign is_uns = f7[4];

  assign c_legal = (insn[6:0] == OPC) && (insn[14:12] == 3'b000) &&
                   f7[6] && (f7[3:2] == 2'b11) && (f7[1:0] != 2'b11);

  for (genvar k = 0; k < NW; k++) begin : g_width
    localparam int W = 8 << k;
    for (genvar i = 0; i < XLEN / W; i++) begin : g_lane
      logic [W:0] ea, eb, d;
      assign ea = {~is_uns & src_a[i*W+W-1], src_a[i*W +: W]};
      assign eb = {~is_uns & src_b[i*W+W-1], src_b[i*W +: W]};
      assign d  = is_sub ? ea - eb : ea + eb;
      assign lane_res[k][i*W +: W] = d[W:1];
    end
  end

  always_comb begin
    c_res = '0;
    if (c_legal) begin
      case (f7[1:0])
        2'b10:   c_res = lane_res[0];
        2'b00:   c_res = lane_res[1];
        default: c_res = lane_res[2];
      endcase
    end
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        legal     <= 1'b0;
        result    <= '0;
        rd_idx    <= '0;
        rs1_idx   <= '0;
        rs2_idx   <= '0;
      end else begin
        out_valid <= in_valid;
        legal     <= c_legal;
        result    <= c_res;
        rd_idx    <= insn[11:7];
        rs1_idx   <= insn[19:15];
        rs2_idx   <= insn[24:20];
      end
    end

    assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    assert_valid_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
    assert_res_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> result == $past(c_res));
  end else begin : g_comb
    assign out_valid = in_valid;
    assign legal     = c_legal;
    assign result    = c_res;
    assign rd_idx    = insn[11:7];
    assign rs1_idx   = insn[19:15];
    assign rs2_idx   = insn[24:20];
  end

  assert_bad_opcode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (insn[6:0] != OPC) |-> !c_legal);

  assert_illegal_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !legal) |-> (result == '0));

  // R4 also: halving the sum of a value with itself returns that value
  assert_add_self_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (c_legal && !is_sub && src_a == src_b) |-> (c_res == src_a));

  assert_sub_self_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_legal && is_sub && src_a == src_b) |-> (c_res == '0));

endmodule

// File: tb/halving_simd_alu_bench.sv
`timescale 1ns/1ps
module halving_simd_alu_bench;

  localparam logic [6:0] OPC = 7'b0111011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] a = '0, b = '0;

  logic        ov64, lg64, ov32, lg32;
  logic [63:0] r64;
  logic [31:0] r32;
  logic [4:0]  rd64, s1_64, s2_64, rd32, s1_32, s2_32;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  halving_simd_alu #(.XLEN(64), .REG_OUT(1'b1)) u_halving_simd_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .src_a(a), .src_b(b), .out_valid(ov64), .legal(lg64), .result(r64),
    .rd_idx(rd64), .rs1_idx(s1_64), .rs2_idx(s2_64));

  halving_simd_alu #(.XLEN(32), .REG_OUT(1'b0)) u_halving_simd_alu_rv32 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .src_a(a[31:0]), .src_b(b[31:0]), .out_valid(ov32), .legal(lg32), .result(r32),
    .rd_idx(rd32), .rs1_idx(s1_32), .rs2_idx(s2_32));

  function automatic logic ref_legal(input logic [31:0] w);
    return (w[6:0] == OPC) && (w[14:12] == 3'b000) && w[31] &&
           (w[28:27] == 2'b11) && (w[26:25] != 2'b11);
  endfunction

  function automatic logic [63:0] ref_res(input int xlen, input logic [31:0] w,
                                          input logic [63:0] x, input logic [63:0] y);
    logic [63:0] r = '0;
    int n;
    logic uns, sb;
    longint m, m1;
    if (!ref_legal(w)) return '0;
    n   = (w[26:25] == 2'b10) ? 8 : (w[26:25] == 2'b00) ? 16 : 32;
    uns = w[29];
    sb  = w[30];
    m   = (longint'(1) << n) - 1;
    m1  = (longint'(1) << (n + 1)) - 1;
    for (int i = 0; i < xlen / n; i++) begin
      longint ea, eb, d, q;
      ea = longint'((x >> (i * n))) & m;
      eb = longint'((y >> (i * n))) & m;
      if (!uns && ea[n-1]) ea = ea - (longint'(1) << n);
      if (!uns && eb[n-1]) eb = eb - (longint'(1) << n);
      d = sb ? ea - eb : ea + eb;
      q = uns ? ((d & m1) >> 1) : (d >>> 1);
      r = r | (64'(q & m) << (i * n));
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [6:0] f7,
                       input logic [63:0] x, input logic [63:0] y,
                       input logic [2:0] f3 = 3'b000, input logic [6:0] op = OPC);
    logic [31:0] w;
    w = {f7, 5'd3, 5'd4, f3, 5'd9, op};
    @(negedge clk);
    insn = w; a = x; b = y; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " result xlen64"}, r64, ref_res(64, w, x, y));
    chk({tag, " legal xlen64"}, {63'd0, lg64}, {63'd0, ref_legal(w)});
    chk({tag, " result xlen32"}, {32'd0, r32}, ref_res(32, w, x, y));
    chk({tag, " legal xlen32"}, {63'd0, lg32}, {63'd0, ref_legal(w)});
    chk("R10 out_valid", {63'd0, ov64}, 64'd1);
    in_valid = 1'b0;
  endtask

  function automatic logic [6:0] f7_of(input logic sb, input logic uns, input logic [1:0] lc);
    return {1'b1, sb, uns, 2'b11, lc};
  endfunction

  task automatic t_reset;
    in_valid = 1'b1;
    insn = {f7_of(0, 0, 2'b10), 5'd1, 5'd2, 3'b000, 5'd3, OPC};
    a = 64'h0101_0101_0101_0101; b = a;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset out_valid", {63'd0, ov64}, 64'd0);
    chk("R10 reset legal", {63'd0, lg64}, 64'd0);
    chk("R10 reset result", r64, 64'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic t_sweep_r1;
    logic [1:0] lcs [3] = '{2'b10, 2'b00, 2'b01};
    for (int l = 0; l < 3; l++)
      for (int s = 0; s < 2; s++)
        for (int u = 0; u < 2; u++) begin
          apply("R1 sweep", f7_of(s[0], u[0], lcs[l]), 64'h1234_5678_9abc_def0, 64'h0fed_cba9_8765_4321);
          apply("R1 sweep", f7_of(s[0], u[0], lcs[l]), 64'h8000_7fff_00ff_ff01, 64'h7f80_8001_ff00_01ff);
        end
  endtask

  task automatic t_signed_add_r3;
    apply("R3 max+max", f7_of(0, 0, 2'b10), 64'h7f7f_7f7f_7f7f_7f7f, 64'h7f7f_7f7f_7f7f_7f7f);
    apply("R3 min+min", f7_of(0, 0, 2'b00), 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000);
    apply("R3 max+min", f7_of(0, 0, 2'b01), 64'h7fff_ffff_8000_0000, 64'h8000_0000_7fff_ffff);
    apply("R3 odd neg", f7_of(0, 0, 2'b10), 64'hff01_fe03_8081_0000, 64'h0000_ff00_0101_ffff);
  endtask

  task automatic t_unsigned_add_r4;
    apply("R4 carry", f7_of(0, 1, 2'b10), 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff);
    apply("R4 carry", f7_of(0, 1, 2'b00), 64'hffff_8000_0001_7fff, 64'h0001_8000_ffff_8001);
    apply("R4 carry", f7_of(0, 1, 2'b01), 64'hffff_ffff_8000_0000, 64'h0000_0001_8000_0000);
  endtask

  task automatic t_signed_sub_r5;
    apply("R5 extremes", f7_of(1, 0, 2'b10), 64'h7f80_7f80_0001_ff00, 64'h807f_7f80_ff01_0001);
    apply("R5 extremes", f7_of(1, 0, 2'b00), 64'h7fff_8000_0000_ffff, 64'h8000_7fff_0001_0001);
    apply("R5 equal", f7_of(1, 0, 2'b01), 64'h89ab_cdef_0123_4567, 64'h89ab_cdef_0123_4567);
  endtask

  task automatic t_unsigned_sub_r6;
    apply("R6 borrow", f7_of(1, 1, 2'b10), 64'h0000_0102_00ff_7f80, 64'hff01_0201_ff00_807f);
    apply("R6 borrow", f7_of(1, 1, 2'b00), 64'h0000_ffff_0001_8000, 64'hffff_0000_0002_7fff);
    apply("R6 borrow", f7_of(1, 1, 2'b01), 64'h0000_0000_ffff_ffff, 64'hffff_ffff_0000_0000);
  endtask

  task automatic t_lanes_r7;
    apply("R7 isolation", f7_of(0, 1, 2'b10), 64'hff00_ff00_ff00_ff00, 64'hff00_ff00_ff00_ff00);
    apply("R7 isolation", f7_of(0, 1, 2'b10), 64'h01ff_02fe_03fd_04fc, 64'hff01_fe02_fd03_fc04);
    apply("R7 isolation", f7_of(1, 0, 2'b00), 64'h0000_8000_0000_8000, 64'h0001_0001_ffff_0001);
  endtask

  task automatic t_scalar_r8;
    apply("R8 scalar", f7_of(0, 0, 2'b01), 64'h0000_0001_7fff_ffff, 64'h0000_0003_0000_0001);
    apply("R8 scalar", f7_of(1, 1, 2'b01), 64'h1111_1111_0000_0001, 64'h2222_2222_0000_0003);
  endtask

  task automatic t_illegal_r2;
    apply("R2 opcode", f7_of(0, 0, 2'b10), 64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222, 3'b000, 7'b0110011);
    apply("R2 funct3", f7_of(0, 0, 2'b10), 64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222, 3'b001);
    apply("R2 width11", f7_of(0, 0, 2'b11), 64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222);
    apply("R2 bit6", 7'b0001110, 64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222);
    apply("R2 bits32", 7'b1000010, 64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222);
  endtask

  task automatic t_fields_r9;
    @(negedge clk);
    insn = {f7_of(0, 0, 2'b00), 5'd21, 5'd10, 3'b000, 5'd17, OPC};
    a = '0; b = '0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R9 rd xlen64", {59'd0, rd64}, 64'd17);
    chk("R9 rs1 xlen64", {59'd0, s1_64}, 64'd10);
    chk("R9 rs2 xlen64", {59'd0, s2_64}, 64'd21);
    chk("R9 rd xlen32", {59'd0, rd32}, 64'd17);
    in_valid = 1'b0;
  endtask

  task automatic t_valid_r10;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 comb valid", {63'd0, ov32}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R10 reg valid drop", {63'd0, ov64}, 64'd0);
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog R10 actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_sweep_r1();
    t_signed_add_r3();
    t_unsigned_add_r4();
    t_signed_sub_r5();
    t_unsigned_sub_r6();
    t_lanes_r7();
    t_scalar_r8();
    t_illegal_r2();
    t_fields_r9();
    t_valid_r10();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule